// File: doc/BRIEF.md
# Tag-Only Set-Associative Hit Tracker

This block answers one question per request: would this address hit in a set-associative cache of a given geometry? It holds a valid flag and a tag for every way of every set and no data at all. A request presents a byte address. One cycle later the block answers with a hit flag and the way that holds the line, or the way that was just filled. Running totals of requests and misses are kept for performance studies.

A miss always allocates the line. The lowest-numbered empty way of the set is taken first. Only when the set is full does the least-recently-used unit choose the victim, and both hits and fills count as use. The geometry comes from parameters (total bytes, line bytes, ways). The number of sets is derived from them, and a configuration that does not divide evenly, or that is not made of powers of two, stops elaboration.

Top module: `tag_presence_tracker`

## Requirements
- R1: The set is selected by address bits [10:6] in the default geometry (64-byte lines, 32 sets). The six line-offset bits [5:0] play no part in the lookup, so two addresses that differ only there hit the same line.
- R2: The stored tag is the full address with its offset and set bits cleared, kept unshifted. Addresses in the same set that differ in any bit from 11 up to the top bit 31 are different lines.
- R3: A hit needs a way that is valid and whose stored tag equals the request tag. The response then reports rsp_hit=1 and the index of that way on rsp_way.
- R4: On a miss into a set that still has an empty way, the lowest-numbered empty way is filled and reported on rsp_way.
- R5: On a miss into a full set, the least-recently-used way is replaced, where both a hit and a fill mark a way as most recently used.
- R6: rsp_valid is high in exactly the cycle after a cycle with req_valid high, and low otherwise.
- R7: Reset (synchronous, active low) clears every valid flag and both counters. The first access to any set after reset misses and fills way 0.
- R8: access_count rises by one for every request, and miss_count rises by one only for a request that misses.
- R9: Sets are independent: filling or touching one set changes neither the contents nor the replacement order of another.
- R10: In a cycle without a request, nothing changes: rsp_valid stays low and both counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A lookup is presented this cycle |
| req_addr | input | ADDR_W (32) | Byte address of the lookup |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | 1 = line was present, 0 = miss (line now filled) |
| rsp_way | output | log2(WAYS) (3) | Way that hit or was filled |
| access_count | output | CNT_W (32) | Requests since reset |
| miss_count | output | CNT_W (32) | Misses since reset |

## Verification
The lookup is tried with addresses that differ only in offset bits, which should hit, and with addresses that differ only in low or top tag bits, which should miss. It is also given a second set, so an offset or set decode error and a truncated tag show up as different hit/way answers. One set is filled way by way, then hit on its oldest line and overflowed repeatedly. The victim order that follows tells a least-recently-used choice apart from a fixed or first-in choice. Idle gaps and a reset in the middle of the run separate counting, response timing and clearing of state.

// File: rtl/tagtrk_pkg.sv
// Shared helpers for the tag presence tracker.
// Assumes: parameters are checked at elaboration with these functions.
package tagtrk_pkg;

    // True when v is a non-zero power of two.
    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/tagtrk_pick.sv
// Lowest-index priority picker: reports whether any bit of vec is set
// and the index of the lowest one.
// Assumes: N >= 2; idx is 0 when nothing is set.
module tagtrk_pick #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tagtrk_match.sv
// Compares one set's stored tags with the request tag.
// Assumes: tags are kept unshifted, with offset and set bits zero.
module tagtrk_match #(
    parameter int WAYS   = 8,
    parameter int ADDR_W = 32
) (
    input  logic [WAYS-1:0][ADDR_W-1:0] row_tag,
    input  logic [WAYS-1:0]             row_valid,
    input  logic [ADDR_W-1:0]           req_tag,
    output logic [WAYS-1:0]             hit_vec
);

    genvar w;
    generate
        for (w = 0; w < WAYS; w++) begin : g_cmp
            // A way matches only when valid and its tag is equal.
            assign hit_vec[w] = row_valid[w] && (row_tag[w] == req_tag);
        end
    endgenerate

endmodule

// File: rtl/tagtrk_lru.sv
// Per-set least-recently-used order, kept as a rank per way:
// rank 0 is the oldest, rank WAYS-1 the newest.
// Assumes: one touch per cycle at most; reset ranks each way by its index.
module tagtrk_lru #(
    parameter int WAYS  = 8,
    parameter int SETS  = 32,
    parameter int WAY_W = $clog2(WAYS),
    parameter int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set,
    output logic [WAY_W-1:0] victim_way,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way
);

    logic [WAY_W-1:0] rank_q [SETS][WAYS];
    logic [WAY_W-1:0] touched_rank;

    // Victim is the way whose rank is zero in the looked-up set.
    always_comb begin
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (rank_q[rd_set][w] == '0) victim_way = WAY_W'(w);
        end
    end

    // Rank currently held by the way being touched.
    assign touched_rank = rank_q[touch_set][touch_way];

    // Move the touched way to newest; close the gap it leaves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    rank_q[s][w] <= WAY_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    rank_q[touch_set][w] <= WAY_W'(WAYS - 1);
                else if (rank_q[touch_set][w] > touched_rank)
                    rank_q[touch_set][w] <= rank_q[touch_set][w] - 1'b1;
            end
        end
    end

endmodule

// File: rtl/tag_presence_tracker.sv
// Tag-only set-associative presence tracker. One lookup per cycle,
// answer one cycle later. Misses allocate: lowest empty way first,
// otherwise the least-recently-used way.
// Assumes: line size, ways and set count are powers of two, with at
// least two ways and two sets.
module tag_presence_tracker #(
    parameter int ADDR_W      = 32,
    parameter int CACHE_BYTES = 16384,
    parameter int BLOCK_BYTES = 64,
    parameter int WAYS        = 8,
    parameter int CNT_W       = 32,
    localparam int SETS       = CACHE_BYTES / (BLOCK_BYTES * WAYS),
    localparam int OFF_W      = $clog2(BLOCK_BYTES),
    localparam int SET_W      = $clog2(SETS),
    localparam int WAY_W      = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [CNT_W-1:0]  access_count,
    output logic [CNT_W-1:0]  miss_count
);
    import tagtrk_pkg::*;

    localparam logic [ADDR_W-1:0] LOW_ONES =
        (ADDR_W'(1) << (OFF_W + SET_W)) - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] TAG_MASK = ~LOW_ONES;

    // Geometry checks at elaboration.
    generate
        if ((CACHE_BYTES % BLOCK_BYTES) != 0)
            $error("cache bytes not a multiple of line bytes");
        if ((CACHE_BYTES % (BLOCK_BYTES * WAYS)) != 0)
            $error("cache bytes not a multiple of set bytes");
        if (!is_pow2(BLOCK_BYTES) || !is_pow2(WAYS) || !is_pow2(SETS))
            $error("line size, ways and sets must be powers of two");
        if (WAYS < 2 || SETS < 2)
            $error("need at least two ways and two sets");
    endgenerate

    logic                 valid_q [SETS][WAYS];
    logic [ADDR_W-1:0]    tag_q   [SETS][WAYS];

    logic [SET_W-1:0]             set_idx;
    logic [ADDR_W-1:0]            req_tag;
    logic [WAYS-1:0][ADDR_W-1:0]  row_tag;
    logic [WAYS-1:0]              row_valid;
    logic [WAYS-1:0]              hit_vec;
    logic                         hit_any;
    logic [WAY_W-1:0]             hit_way;
    logic                         free_any;
    logic [WAY_W-1:0]             free_way;
    logic [WAY_W-1:0]             victim_way;
    logic [WAY_W-1:0]             fill_way;
    logic [WAY_W-1:0]             sel_way;
    logic                         do_fill;

    // Address split: offset low, then set, then tag.
    assign set_idx = req_addr[OFF_W +: SET_W];
    assign req_tag = req_addr & TAG_MASK;

    // Read out the addressed set.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            row_tag[w]   = tag_q[set_idx][w];
            row_valid[w] = valid_q[set_idx][w];
        end
    end

    tagtrk_match #(.WAYS(WAYS), .ADDR_W(ADDR_W)) u_match (
        .row_tag   (row_tag),
        .row_valid (row_valid),
        .req_tag   (req_tag),
        .hit_vec   (hit_vec)
    );

    tagtrk_pick #(.N(WAYS), .IDX_W(WAY_W)) u_hit_pick (
        .vec   (hit_vec),
        .found (hit_any),
        .idx   (hit_way)
    );

    tagtrk_pick #(.N(WAYS), .IDX_W(WAY_W)) u_free_pick (
        .vec   (~row_valid),
        .found (free_any),
        .idx   (free_way)
    );

    tagtrk_lru #(.WAYS(WAYS), .SETS(SETS), .WAY_W(WAY_W), .SET_W(SET_W)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_set     (set_idx),
        .victim_way (victim_way),
        .touch_en   (req_valid),
        .touch_set  (set_idx),
        .touch_way  (sel_way)
    );

    // Choose the way to report and, on a miss, to fill.
    assign fill_way = free_any ? free_way : victim_way;
    assign sel_way  = hit_any ? hit_way : fill_way;
    assign do_fill  = req_valid && !hit_any;

    // Response register and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_way      <= '0;
            access_count <= '0;
            miss_count   <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_hit      <= hit_any;
                rsp_way      <= sel_way;
                access_count <= access_count + 1'b1;
                if (!hit_any) miss_count <= miss_count + 1'b1;
            end
        end
    end

    // Valid flags: cleared by reset, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    valid_q[s][w] <= 1'b0;
        end else if (do_fill) begin
            valid_q[set_idx][fill_way] <= 1'b1;
        end
    end

    // Tag array: written on a fill, never reset (guarded by valid).
    always_ff @(posedge clk) begin
        if (do_fill) tag_q[set_idx][fill_way] <= req_tag;
    end

endmodule

// File: rtl/tagtrk_checker.sv
// Port-level properties of the tracker, bound to every instance.
// Assumes: reset is low at time zero.
module tagtrk_checker #(
    parameter int ADDR_W = 32,
    parameter int WAY_W  = 3,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [WAY_W-1:0]  rsp_way,
    input logic [CNT_W-1:0]  access_count,
    input logic [CNT_W-1:0]  miss_count
);

    // R6: a request is answered in the next cycle.
    p_rsp_after_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R6 / R10: no request, no response.
    p_no_rsp_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R8: each request adds one access.
    p_access_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> access_count == $past(access_count) + 1'b1);

    // R8: the miss count follows the reported outcome.
    p_miss_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_hit ? (miss_count == $past(miss_count))
                               : (miss_count == $past(miss_count) + 1'b1)));

    // R10: counters hold across idle cycles.
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(access_count) && $stable(miss_count)));

    // R3: a line just accessed hits on an immediate repeat.
    p_repeat_hits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(req_valid) && req_addr == $past(req_addr))
        |=> (rsp_hit && rsp_way == $past(rsp_way)));

endmodule

bind tag_presence_tracker tagtrk_checker #(
    .ADDR_W (ADDR_W),
    .WAY_W  (WAY_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_way      (rsp_way),
    .access_count (access_count),
    .miss_count   (miss_count)
);

// File: tb/tag_presence_tracker_test.sv
// Bench for the tracker in its default geometry:
// offset [5:0], set [10:6], tag [31:11], 8 ways.
module tag_presence_tracker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [2:0]  rsp_way;
    logic [31:0] access_count;
    logic [31:0] miss_count;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    tag_presence_tracker uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .rsp_valid    (rsp_valid),
        .rsp_hit      (rsp_hit),
        .rsp_way      (rsp_way),
        .access_count (access_count),
        .miss_count   (miss_count)
    );

    function automatic logic [31:0] mk(input logic [20:0] t, input logic [4:0] s,
                                       input logic [5:0] o);
        return {t, s, o};
    endfunction

    typedef struct packed {
        logic [31:0] addr;
        logic        hit;
        logic [2:0]  way;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_08C0, 1'b0, 3'd0},   // t1 s3: first touch fills way 0 (R7)
        '{32'h0000_08C5, 1'b1, 3'd0},   // offset only differs: hit (R1)
        '{32'h0000_10C0, 1'b0, 3'd1},   // t2 s3: next empty way (R2, R4)
        '{32'h0000_0900, 1'b0, 3'd0},   // t1 s4: other set own way 0 (R9)
        '{32'h0000_18C0, 1'b0, 3'd2},   // t3 s3 (R4)
        '{32'h0000_20C0, 1'b0, 3'd3},   // t4 s3
        '{32'h0000_28C0, 1'b0, 3'd4},   // t5 s3
        '{32'h0000_30C0, 1'b0, 3'd5},   // t6 s3
        '{32'h0000_38C0, 1'b0, 3'd6},   // t7 s3
        '{32'h0000_40C0, 1'b0, 3'd7},   // t8 s3: set full
        '{32'h0000_08C0, 1'b1, 3'd0},   // t1 s3 hit, way 0 becomes newest (R3)
        '{32'h0000_48C0, 1'b0, 3'd1},   // t9: oldest is way 1 (R5)
        '{32'h0000_10C0, 1'b0, 3'd2},   // t2 again: evicted, oldest way 2 (R5)
        '{32'h0000_18C0, 1'b0, 3'd3},   // t3 again: way 3 (R5)
        '{32'h0000_08C0, 1'b1, 3'd0},   // t1 survived (R5)
        '{32'h0000_0900, 1'b1, 3'd0},   // s4 untouched by s3 traffic (R9)
        '{32'h8000_0900, 1'b0, 3'd1}    // top tag bit differs: miss (R2)
    };

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Present one request, then sample its response in the following cycle.
    task automatic access(input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state.
        check(rsp_valid == 1'b0, "R7 rsp_valid after reset", 64'(rsp_valid), 0);
        check(access_count == 0, "R7 access_count after reset", 64'(access_count), 0);
        check(miss_count == 0, "R7 miss_count after reset", 64'(miss_count), 0);
        rst_n = 1'b1;

        // Vector table walk (R1..R5, R9).
        for (int i = 0; i < NV; i++) begin
            access(VECS[i].addr);
            check(rsp_valid == 1'b1, $sformatf("R6 rsp_valid vec %0d", i), 64'(rsp_valid), 1);
            check(rsp_hit == VECS[i].hit, $sformatf("R3 hit vec %0d", i),
                  64'(rsp_hit), 64'(VECS[i].hit));
            check(rsp_way == VECS[i].way, $sformatf("R4 way vec %0d", i),
                  64'(rsp_way), 64'(VECS[i].way));
        end

        // R8: 17 requests, 13 misses.
        check(access_count == 17, "R8 access_count", 64'(access_count), 17);
        check(miss_count == 13, "R8 miss_count", 64'(miss_count), 13);

        // R10 / R6: idle cycles leave everything unchanged.
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0, "R6 rsp_valid idle", 64'(rsp_valid), 0);
        check(access_count == 17, "R10 access_count idle", 64'(access_count), 17);
        check(miss_count == 13, "R10 miss_count idle", 64'(miss_count), 13);

        // R5: back-to-back overflow of set 3 continues the LRU order (way 4 next).
        access(mk(21'd10, 5'd3, 6'd0));
        check(rsp_hit == 1'b0 && rsp_way == 3'd4, "R5 next victim way 4",
              64'({rsp_hit, rsp_way}), 64'({1'b0, 3'd4}));

        // R7: reset mid-run forgets every line.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check(access_count == 0 && miss_count == 0, "R7 counters cleared",
              64'({access_count, miss_count}), 0);
        access(mk(21'd1, 5'd3, 6'd0));
        check(rsp_hit == 1'b0 && rsp_way == 3'd0, "R7 refill way 0 after reset",
              64'({rsp_hit, rsp_way}), 64'({1'b0, 3'd0}));
        check(access_count == 1 && miss_count == 1, "R8 counts after reset",
              64'({access_count, miss_count}), 64'({32'd1, 32'd1}));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule